// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns the one-bit output of a delta-sigma modulator into signed multi-bit words at a reduced rate. It is built as a cascaded integrator-comb filter. At run time it can give a first-, second- or third-order sinc response. It also offers a fast variant, which is a second-order sinc multiplied by (1 + z^-2·OSR). The oversampling ratio is a power of two chosen at run time, and one word comes out for every OSR enabled modulator samples.

Each enabled sample counts as +1 when the bit is high and as -1 when it is low. The raw filter value is scaled so that full scale lands on the range of a signed output word. The word is given twice: in two's complement and in offset binary. A settled flag marks the words whose whole impulse response comes from samples taken under the current configuration. Changing the configuration clears the filter state and restarts settling.

Top module: `sdf_decimator`

## Requirements
- R1: After reset, word_valid and word_settled are 0, word_signed is 0 and word_offset is 16'h8000. The captured configuration is third order at the largest ratio.
- R2: One word_valid pulse, one cycle wide, comes out per OSR = 2^osr_log2 enabled samples. It appears at the clock edge after the edge that takes the OSR-th sample. Cycles with mod_en low do not advance the count.
- R3: filt_sel encodes the response: 0 is sinc1, 1 is sinc2 and 2 is sinc3. The raw word is the order-N sinc of the ±1 sample stream, evaluated at the last sample of the word. Samples taken before the last clear count as zero.
- R4: filt_sel 3 gives the fast variant. Its raw word is the sinc2 raw word of the current word plus the sinc2 raw word from two words earlier, which counts as zero before the clear.
- R5: The full-scale magnitude is 2^k, where k = order·osr_log2, plus 1 for the fast variant. The output is floor(raw·2^(15−k)), saturated to the range −32768..32767.
- R6: word_offset always equals word_signed with its most significant bit inverted.
- R7: word_settled is high on a word whose index since the last clear is at least 1 (sinc1), 2 (sinc2), 3 (sinc3) or 4 (fast). It is low on earlier words.
- R8: When the effective OSR or filt_sel differs from the captured configuration, the state is cleared and the new configuration is captured. Other effects at that edge: the sample offered at that edge is discarded, any word due at that edge is dropped, and word_settled goes low.
- R9: An osr_log2 below 4 acts as 4, and an osr_log2 above 8 acts as 8.
- R10: A stream with 50% ones (alternating bits) gives settled words of 0. All ones saturates to 32767, and all zeros gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Modulator sample enable |
| mod_bit | input | 1 | Modulator bit |
| osr_log2 | input | 4 | Log2 of the oversampling ratio |
| filt_sel | input | 2 | Response select |
| word_valid | output | 1 | New word strobe |
| word_signed | output | 16 | Result in two's complement |
| word_offset | output | 16 | Result in offset binary |
| word_settled | output | 1 | Word is fully settled |

## Verification
A word is due exactly one clock after the edge that takes the OSR-th enabled sample of that word. On a configuration change, the change itself shows up in the outputs at the very edge where it is seen. The bench keeps a behavioural model that holds each computed word as pending for one edge. It drives inputs and compares all outputs at the falling edge of every cycle, so each check lands in the cycle after the edge that produced the value. Explicit checks on word spacing, saturation and clearing are read at the same falling-edge points.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   localparam int ORDER_MAX = 3;

   typedef enum logic [1:0] {
      FT_SINC1 = 2'd0,
      FT_SINC2 = 2'd1,
      FT_SINC3 = 2'd2,
      FT_FAST2 = 2'd3
   } filt_e;

   function automatic logic [1:0] order_of(input filt_e f);
      case (f)
         FT_SINC1: order_of = 2'd1;
         FT_SINC3: order_of = 2'd3;
         default:  order_of = 2'd2;
      endcase
   endfunction

   function automatic logic [2:0] settle_words(input filt_e f, input logic fast_ok);
      case (f)
         FT_SINC1: settle_words = 3'd1;
         FT_SINC2: settle_words = 3'd2;
         FT_SINC3: settle_words = 3'd3;
         default:  settle_words = fast_ok ? 3'd4 : 3'd2;
      endcase
   endfunction
endpackage

// File: rtl/sdf_integrators.sv
module sdf_integrators #(
   parameter int ACC_W  = 26,
   parameter int STAGES = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         en,
   input  logic                         bit_in,
   output logic [STAGES-1:0][ACC_W-1:0] acc_o
);
   logic [ACC_W-1:0]              step;
   logic [STAGES-1:0][ACC_W-1:0]  acc_q;
   logic [STAGES-1:0][ACC_W-1:0]  nxt;

   assign step = {{(ACC_W-1){~bit_in}}, 1'b1};

   always_comb begin
      nxt[0] = acc_q[0] + step;
      for (int s = 1; s < STAGES; s++) begin
         nxt[s] = acc_q[s] + nxt[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= nxt;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/sdf_sequencer.sv
module sdf_sequencer #(
   parameter int PH_W = 8,
   parameter int L_W  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           en,
   input  logic [L_W-1:0] osr_l,
   input  logic [2:0]     need,
   output logic           dump,
   output logic           dump_settled
);
   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] lim;
   logic [2:0]      wcnt;
   logic [2:0]      wnext;
   logic            at_end;

   always_comb begin
      lim    = ~({PH_W{1'b1}} << osr_l);
      at_end = (phase == lim);
      wnext  = (wcnt >= 3'd4) ? wcnt : wcnt + 3'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= '0;
         wcnt         <= '0;
         dump         <= 1'b0;
         dump_settled <= 1'b0;
      end else if (clr) begin
         phase        <= '0;
         wcnt         <= '0;
         dump         <= 1'b0;
         dump_settled <= 1'b0;
      end else begin
         dump <= en && at_end;
         if (en) begin
            if (at_end) begin
               phase        <= '0;
               wcnt         <= wnext;
               dump_settled <= (wnext >= need);
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

   p_dump_from_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dump |-> $past(en));
endmodule

// File: rtl/sdf_combs.sv
module sdf_combs
   import sdf_pkg::*;
#(
   parameter int ACC_W    = 26,
   parameter int STAGES   = 3,
   parameter int L_W      = 4,
   parameter bit HAS_FAST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         dump,
   input  filt_e                        sel,
   input  logic [L_W-1:0]               osr_l,
   input  logic [STAGES-1:0][ACC_W-1:0] acc_i,
   output logic signed [ACC_W-1:0]      raw_o
);
   logic [1:0]                   order;
   logic [ACC_W-1:0]             src;
   logic [STAGES-1:0][ACC_W-1:0] dly;
   logic [STAGES-1:0][ACC_W-1:0] dif;
   logic [ACC_W-1:0]             base;
   logic [ACC_W-1:0]             fast_val;

   always_comb begin
      order  = order_of(sel);
      src    = acc_i[order - 2'd1];
      dif[0] = src - dly[0];
      for (int i = 1; i < STAGES; i++) begin
         dif[i] = dif[i-1] - dly[i];
      end
      base = dif[order - 2'd1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly <= '0;
      end else if (clr) begin
         dly <= '0;
      end else if (dump) begin
         dly[0] <= src;
         for (int i = 1; i < STAGES; i++) begin
            dly[i] <= dif[i-1];
         end
      end
   end

   generate
      if (HAS_FAST) begin : g_fast
         logic [ACC_W-1:0] hold1;
         logic [ACC_W-1:0] hold2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold1 <= '0;
               hold2 <= '0;
            end else if (clr) begin
               hold1 <= '0;
               hold2 <= '0;
            end else if (dump) begin
               hold1 <= dif[1];
               hold2 <= hold1;
            end
         end
         assign fast_val = dif[1] + hold2;
      end else begin : g_nofast
         assign fast_val = dif[1];
      end
   endgenerate

   assign raw_o = (sel == FT_FAST2) ? $signed(fast_val) : $signed(base);

   logic signed [ACC_W-1:0] one_lim;
   assign one_lim = $signed({{(ACC_W-1){1'b0}}, 1'b1} << osr_l);

   p_sinc1_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dump && sel == FT_SINC1) |-> (raw_o <= one_lim && raw_o >= -one_lim));
endmodule

// File: rtl/sdf_scaler.sv
module sdf_scaler #(
   parameter int ACC_W = 26,
   parameter int OUT_W = 16,
   parameter int L_W   = 4
) (
   input  logic signed [ACC_W-1:0] raw_i,
   input  logic [1:0]              order,
   input  logic                    fast,
   input  logic [L_W-1:0]          osr_l,
   output logic [OUT_W-1:0]        word_o
);
   localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

   int                      kk;
   logic signed [ACC_W-1:0] shifted;

   always_comb begin
      kk = int'(order) * int'(osr_l) + (fast ? 1 : 0);
      if (kk > OUT_W - 1) begin
         shifted = raw_i >>> (kk - (OUT_W - 1));
      end else begin
         shifted = raw_i <<< ((OUT_W - 1) - kk);
      end
      if (shifted > HI) begin
         word_o = HI[OUT_W-1:0];
      end else if (shifted < LO) begin
         word_o = LO[OUT_W-1:0];
      end else begin
         word_o = shifted[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/sdf_decimator.sv
module sdf_decimator
   import sdf_pkg::*;
#(
   parameter int OUT_W     = 16,
   parameter int OSR_L_MIN = 4,
   parameter int OSR_L_MAX = 8,
   parameter bit HAS_FAST  = 1'b1,
   localparam int L_W      = $clog2(OSR_L_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_en,
   input  logic             mod_bit,
   input  logic [L_W-1:0]   osr_log2,
   input  logic [1:0]       filt_sel,
   output logic             word_valid,
   output logic [OUT_W-1:0] word_signed,
   output logic [OUT_W-1:0] word_offset,
   output logic             word_settled
);
   localparam int ACC_RAW = 2 + ORDER_MAX * OSR_L_MAX;
   localparam int ACC_W   = (ACC_RAW > OUT_W + 1) ? ACC_RAW : OUT_W + 1;

   generate
      if (OSR_L_MIN < 1 || OSR_L_MAX < OSR_L_MIN || OUT_W < 2) begin : g_bad_cfg
         $error("sdf_decimator: illegal parameter set");
      end
   endgenerate

   logic [L_W-1:0] osr_eff;
   logic [L_W-1:0] osr_q;
   filt_e          sel_q;
   filt_e          sel_in;
   logic           chg;

   always_comb begin
      sel_in = filt_e'(filt_sel);
      if (osr_log2 < L_W'(OSR_L_MIN)) begin
         osr_eff = L_W'(OSR_L_MIN);
      end else if (osr_log2 > L_W'(OSR_L_MAX)) begin
         osr_eff = L_W'(OSR_L_MAX);
      end else begin
         osr_eff = osr_log2;
      end
      chg = (osr_eff != osr_q) || (sel_in != sel_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr_q <= L_W'(OSR_L_MAX);
         sel_q <= FT_SINC3;
      end else begin
         osr_q <= osr_eff;
         sel_q <= sel_in;
      end
   end

   logic [ORDER_MAX-1:0][ACC_W-1:0] acc;
   logic                            dump;
   logic                            dump_settled;
   logic signed [ACC_W-1:0]         raw;
   logic [OUT_W-1:0]                scaled;
   logic                            fast_on;

   assign fast_on = HAS_FAST && (sel_q == FT_FAST2);

   sdf_integrators #(.ACC_W(ACC_W), .STAGES(ORDER_MAX)) u_int (
      .clk(clk), .rst_n(rst_n), .clr(chg), .en(mod_en), .bit_in(mod_bit), .acc_o(acc));

   sdf_sequencer #(.PH_W(OSR_L_MAX), .L_W(L_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(chg), .en(mod_en), .osr_l(osr_q),
      .need(settle_words(sel_q, HAS_FAST)), .dump(dump), .dump_settled(dump_settled));

   sdf_combs #(.ACC_W(ACC_W), .STAGES(ORDER_MAX), .L_W(L_W), .HAS_FAST(HAS_FAST)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(chg), .dump(dump), .sel(sel_q), .osr_l(osr_q),
      .acc_i(acc), .raw_o(raw));

   sdf_scaler #(.ACC_W(ACC_W), .OUT_W(OUT_W), .L_W(L_W)) u_scl (
      .raw_i(raw), .order(order_of(sel_q)), .fast(fast_on), .osr_l(osr_q), .word_o(scaled));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_valid   <= 1'b0;
         word_signed  <= '0;
         word_settled <= 1'b0;
      end else if (chg) begin
         word_valid   <= 1'b0;
         word_settled <= 1'b0;
      end else begin
         word_valid <= dump;
         if (dump) begin
            word_signed  <= scaled;
            word_settled <= dump_settled;
         end
      end
   end

   assign word_offset = {~word_signed[OUT_W-1], word_signed[OUT_W-2:0]};

   p_valid_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   p_drop_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (!word_valid && !word_settled));

   p_settle_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_settled) |-> word_valid);

   p_settle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_settled && !chg) |=> word_settled);
endmodule

// File: tb/sim_sdf_decimator.sv
module sim_sdf_decimator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_en = 1'b0;
   logic        mod_bit = 1'b0;
   logic [3:0]  osr_log2 = 4'd8;
   logic [1:0]  filt_sel = 2'd2;
   logic        word_valid;
   logic [15:0] word_signed;
   logic [15:0] word_offset;
   logic        word_settled;

   always #5 clk = ~clk;

   sdf_decimator u0 (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
      .osr_log2(osr_log2), .filt_sel(filt_sel), .word_valid(word_valid),
      .word_signed(word_signed), .word_offset(word_offset), .word_settled(word_settled));

   int checks = 0;
   int errors = 0;

   // behavioural model state
   int     xs[$];
   int     y1[$];
   int     y2[$];
   int     y3[$];
   int     cq_l = 8;
   int     cq_f = 2;
   int     nw = 0;
   bit     pend = 0;
   int     pend_val = 0;
   bit     pend_set = 0;
   bit     exp_valid = 0;
   int     exp_s = 0;
   bit     exp_settled = 0;
   int     cyc_n = 0;
   int     prev_vcyc = -1;
   int     last_gap = 0;
   int     last_word = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc_n);
      end
   endtask

   function automatic int clamp_l(input int l);
      return (l < 4) ? 4 : (l > 8) ? 8 : l;
   endfunction

   function automatic int scale(input longint raw, input int l, input int fs);
      int k;
      longint v;
      k = ((fs == 0) ? 1 : (fs == 2) ? 3 : 2) * l + ((fs == 3) ? 1 : 0);
      if (k > 15) v = raw >>> (k - 15);
      else        v = raw <<< (15 - k);
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      return int'(v);
   endfunction

   function automatic int at(ref int q[$], input int i);
      return (i < 0) ? 0 : q[i];
   endfunction

   function automatic void model_clear();
      xs.delete(); y1.delete(); y2.delete(); y3.delete();
      nw = 0;
      pend = 0;
   endfunction

   function automatic void model_push(input bit b);
      int t, osr, x;
      longint raw;
      osr = 1 << cq_l;
      x = b ? 1 : -1;
      t = xs.size();
      xs.push_back(x);
      y1.push_back(at(y1, t-1) + x - at(xs, t-osr));
      y2.push_back(at(y2, t-1) + y1[t] - at(y1, t-osr));
      y3.push_back(at(y3, t-1) + y2[t] - at(y2, t-osr));
      if (xs.size() % osr == 0) begin
         nw++;
         case (cq_f)
            0: raw = y1[t];
            1: raw = y2[t];
            2: raw = y3[t];
            default: raw = longint'(y2[t]) + at(y2, t - 2*osr);
         endcase
         pend = 1;
         pend_val = scale(raw, cq_l, cq_f);
         pend_set = (nw >= ((cq_f == 3) ? 4 : cq_f + 1));
      end
   endfunction

   // One cycle: compare at falling edge, then drive inputs and advance the model.
   task automatic cyc(input bit en, input bit b, input int l_raw, input int fs);
      int eff;
      @(negedge clk);
      cyc_n++;
      check(word_valid == exp_valid, "R2 valid", word_valid, exp_valid);
      check(word_settled == exp_settled, "R7 settled", word_settled, exp_settled);
      if (exp_valid) begin
         check($signed(word_signed) == exp_s, (cq_f == 3) ? "R4 R5 word" : "R3 R5 word",
               $signed(word_signed), exp_s);
         check(word_offset == (16'(exp_s) ^ 16'h8000), "R6 offset", word_offset,
               16'(exp_s) ^ 16'h8000);
      end
      if (word_valid) begin
         if (prev_vcyc >= 0) last_gap = cyc_n - prev_vcyc;
         prev_vcyc = cyc_n;
         last_word = $signed(word_signed);
      end
      mod_en = en;
      mod_bit = b;
      osr_log2 = 4'(l_raw);
      filt_sel = 2'(fs);
      eff = clamp_l(l_raw);
      if (eff != cq_l || fs != cq_f) begin
         cq_l = eff;
         cq_f = fs;
         model_clear();
         exp_valid = 0;
         exp_settled = 0;
         prev_vcyc = -1;
      end else begin
         exp_valid = pend;
         if (pend) begin
            exp_s = pend_val;
            exp_settled = pend_set;
         end
         pend = 0;
         if (en) model_push(b);
      end
   endtask

   // pattern: 0 alternate, 1 ones, 2 zeros, 3 random, 4 four-in-five ones
   task automatic run(input int n, input int pat, input int en_pct, input int l, input int fs);
      int k = 0;
      for (int i = 0; i < n; i++) begin
         bit en, b;
         en = ($urandom_range(99) < en_pct);
         case (pat)
            0: b = k[0];
            1: b = 1'b1;
            2: b = 1'b0;
            3: b = 1'($urandom_range(1));
            default: b = ((k % 5) != 4);
         endcase
         if (en) k++;
         cyc(en, b, l, fs);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc_n);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(word_valid == 0, "R1 valid", word_valid, 0);
      check(word_settled == 0, "R1 settled", word_settled, 0);
      check(word_signed == 0, "R1 signed", word_signed, 0);
      check(word_offset == 16'h8000, "R1 offset", word_offset, 16'h8000);
      rst_n = 1'b1;

      // R10: alternating bits, sinc3, OSR 16, settle to 0
      run(16 * 6 + 4, 0, 100, 4, 2);
      check(last_word == 0, "R10 half ones", last_word, 0);
      check(last_gap == 16, "R2 gap", last_gap, 16);
      run(16 * 5 + 4, 1, 100, 4, 2);
      check(last_word == 32767, "R10 all ones", last_word, 32767);
      run(16 * 5 + 4, 2, 100, 4, 2);
      check(last_word == -32768, "R10 all zeros", last_word, -32768);

      // R3/R4/R5 with random enables and several ratios
      run(900, 3, 60, 4, 0);
      run(900, 3, 70, 5, 1);
      run(1200, 4, 80, 5, 1);
      run(1400, 3, 75, 6, 2);
      run(1200, 3, 90, 4, 3);
      run(2000, 3, 90, 5, 3);
      run(256 * 5 + 20, 3, 100, 8, 2);
      run(256 * 3 + 20, 4, 100, 8, 0);

      // R8: change in the middle of a word
      run(16 * 4 + 7, 3, 100, 4, 1);
      cyc(1, 1, 4, 2);
      cyc(1, 1, 4, 2);
      check(word_settled == 0 && word_valid == 0, "R8 cleared", word_settled, 0);
      run(16 * 4, 3, 100, 4, 2);
      check(word_settled == 1, "R8 resettled", word_settled, 1);

      // R9: clamping of the ratio
      run(16 * 4 + 4, 3, 100, 2, 0);
      check(last_gap == 16, "R9 low clamp", last_gap, 16);
      run(256 * 3 + 4, 3, 100, 15, 0);
      check(last_gap == 256, "R9 high clamp", last_gap, 256);

      run(4, 3, 0, 15, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule